// File: doc/BRIEF.md
# Pulse Swallow Feedback Divider

This block is the digital core of a frequency synthesizer's feedback path. It divides a high-rate input by P·N+A, where P is the base modulus of a dual-modulus prescaler, N is an 11-bit main count and A is a 7-bit swallow count. The high-rate input is modelled as a single-cycle enable (`vco_tick`) on the system clock. For each complete division cycle the block issues one comparison pulse, which feeds a phase detector.

Inside, a prescaler model counts ticks in segments of P+1 while swallow counts remain, and in segments of P once they are used up. A main counter ends the division cycle after N segments. At that point both counters reload and the new configuration is captured. The channel flavour is a parameter, and it fixes which two base moduli the select input chooses between. Reprogramming is safe at any time, because a running cycle always finishes with the settings it started with.

Top module: `swallow_fb_divider`

## Requirements
- R1: During reset and in the first clock after reset is released, `cmp_pulse` is low. In that first clock the block captures `div_n`, `div_a` and `mod_sel`, and it ignores `vco_tick`.
- R2: The number of `vco_tick` pulses from one `cmp_pulse` to the next (and from the capture clock to the first pulse) is P·N+A when A < N.
- R3: With `RX_CHAN` = 0, `mod_sel` = 1 selects P = 16 and `mod_sel` = 0 selects P = 32.
- R4: With `RX_CHAN` = 1, `mod_sel` = 1 selects P = 32 and `mod_sel` = 0 selects P = 64.
- R5: Each prescaler segment lasts P+1 ticks while swallow counts remain and P ticks afterwards. The phase count never exceeds P.
- R6: When A ≥ N, every one of the N segments is P+1 ticks long, so the ratio is (P+1)·N.
- R7: A `div_n` value below 3 is treated as 3.
- R8: `div_n`, `div_a` and `mod_sel` are sampled only in the clock in which a division cycle ends (or in the capture clock). Changes at any other time do not alter the cycle in progress.
- R9: `cmp_pulse` is high for exactly one clock. It rises in the clock after the edge that accepts the final tick of a cycle.
- R10: Clocks with `vco_tick` low do not advance the division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_tick | input | 1 | One high-rate input event per clock in which it is high |
| div_n | input | N_W | Main count N |
| div_a | input | A_W | Swallow count A |
| mod_sel | input | 1 | Base modulus select |
| cmp_pulse | output | 1 | One-clock pulse per completed division |

## Verification
The main stimulus is a sweep of every A from 0 to N−1 for several small N, run under both select values on a transmit-flavour and a receive-flavour instance at the same time. Mismatched ratios between the two instances separate errors in the modulus choice from errors in the swallow arithmetic. The input tick has periodic gaps, which shows that tick events are counted rather than clocks. Further cases cover A ≥ N, N below 3, a large N with the maximum A, and a mid-cycle reprogramming. The reprogramming case shows whether the settings are sampled only at the cycle boundary.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

  // Segment mode of the prescaler model
  typedef enum logic {
    SEG_PLAIN   = 1'b0,
    SEG_SWALLOW = 1'b1
  } seg_e;

  // Base modulus for a channel flavour and select value
  function automatic int unsigned base_modulus(input bit rx_chan, input bit sel_hi);
    if (rx_chan) return sel_hi ? 32 : 64;
    return sel_hi ? 16 : 32;
  endfunction

  // Lower clamp used for the main count
  function automatic int unsigned floor_at(input int unsigned v, input int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

  // Ticks per division: swallow segments beyond N cannot occur
  function automatic int unsigned full_ratio(input int unsigned p,
                                             input int unsigned n,
                                             input int unsigned a);
    int unsigned used_a;
    used_a = (a < n) ? a : n;
    return p * n + used_a;
  endfunction

endpackage

// File: rtl/swdiv_cfg_hold.sv
module swdiv_cfg_hold #(
  parameter int unsigned N_W   = 11,
  parameter int unsigned A_W   = 7,
  parameter int unsigned PC_W  = 7,
  parameter int unsigned N_MIN = 3,
  parameter int unsigned P_HI  = 16,
  parameter int unsigned P_LO  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [N_W-1:0]  n_in,
  input  logic [A_W-1:0]  a_in,
  input  logic            sel_in,
  output logic            primed,
  output logic [PC_W-1:0] p_act,
  output logic [PC_W-1:0] p_nxt,
  output logic [N_W-1:0]  n_eff,
  output logic [A_W-1:0]  a_eff
);

  always_comb begin
    n_eff = N_W'(swdiv_pkg::floor_at(32'(n_in), N_MIN));
    a_eff = a_in;
    p_nxt = sel_in ? PC_W'(P_HI) : PC_W'(P_LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      p_act  <= '0;
    end else if (load) begin
      primed <= 1'b1;
      p_act  <= p_nxt;
    end
  end

endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
  parameter int unsigned PC_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            load,
  input  logic            plus1,
  input  logic [PC_W-1:0] p_act,
  output logic [PC_W-1:0] pre_cnt,
  output logic            wrap
);

  logic [PC_W-1:0] seg_len;

  always_comb begin
    seg_len = p_act + {{(PC_W-1){1'b0}}, plus1};
    wrap    = tick && (pre_cnt == seg_len - PC_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (load) begin
      pre_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= wrap ? '0 : pre_cnt + PC_W'(1);
    end
  end

endmodule

// File: rtl/swdiv_seg_counter.sv
module swdiv_seg_counter #(
  parameter int unsigned N_W = 11,
  parameter int unsigned A_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic              load,
  input  logic [N_W-1:0]    n_eff,
  input  logic [A_W-1:0]    a_eff,
  output logic [N_W-1:0]    n_left,
  output logic [A_W-1:0]    a_left,
  output swdiv_pkg::seg_e   seg_mode,
  output logic              last_seg
);

  always_comb begin
    seg_mode = (a_left != '0) ? swdiv_pkg::SEG_SWALLOW : swdiv_pkg::SEG_PLAIN;
    last_seg = (n_left == N_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_left <= '0;
      a_left <= '0;
    end else if (load) begin
      n_left <= n_eff;
      a_left <= a_eff;
    end else if (wrap) begin
      n_left <= n_left - N_W'(1);
      if (a_left != '0) a_left <= a_left - A_W'(1);
    end
  end

endmodule

// File: rtl/swallow_fb_divider.sv
module swallow_fb_divider #(
  parameter bit          RX_CHAN = 1'b0,
  parameter int unsigned N_W     = 11,
  parameter int unsigned A_W     = 7,
  parameter int unsigned N_MIN   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vco_tick,
  input  logic [N_W-1:0] div_n,
  input  logic [A_W-1:0] div_a,
  input  logic           mod_sel,
  output logic           cmp_pulse
);

  localparam int unsigned P_HI  = swdiv_pkg::base_modulus(RX_CHAN, 1'b1);
  localparam int unsigned P_LO  = swdiv_pkg::base_modulus(RX_CHAN, 1'b0);
  localparam int unsigned P_MAX = (P_HI > P_LO) ? P_HI : P_LO;
  localparam int unsigned PC_W  = $clog2(P_MAX + 2);

  // Named internal events
  logic            primed;
  logic            tick_run;
  logic            wrap;
  logic            last_seg;
  logic            cycle_end;
  logic            load;
  logic [PC_W-1:0] p_act;
  logic [PC_W-1:0] p_nxt;
  logic [PC_W-1:0] pre_cnt;
  logic [N_W-1:0]  n_eff;
  logic [A_W-1:0]  a_eff;
  logic [N_W-1:0]  n_left;
  logic [A_W-1:0]  a_left;
  swdiv_pkg::seg_e seg_mode;

  assign tick_run  = vco_tick & primed;
  assign cycle_end = wrap & last_seg;
  assign load      = ~primed | cycle_end;

  swdiv_cfg_hold #(
    .N_W(N_W), .A_W(A_W), .PC_W(PC_W), .N_MIN(N_MIN), .P_HI(P_HI), .P_LO(P_LO)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .n_in(div_n), .a_in(div_a), .sel_in(mod_sel),
    .primed(primed), .p_act(p_act), .p_nxt(p_nxt),
    .n_eff(n_eff), .a_eff(a_eff)
  );

  swdiv_prescaler #(.PC_W(PC_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick_run), .load(load),
    .plus1(seg_mode == swdiv_pkg::SEG_SWALLOW), .p_act(p_act),
    .pre_cnt(pre_cnt), .wrap(wrap)
  );

  swdiv_seg_counter #(.N_W(N_W), .A_W(A_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .load(load),
    .n_eff(n_eff), .a_eff(a_eff),
    .n_left(n_left), .a_left(a_left), .seg_mode(seg_mode), .last_seg(last_seg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_pulse <= 1'b0;
    else        cmp_pulse <= cycle_end;
  end

endmodule

// File: rtl/swdiv_chk.sv
module swdiv_chk #(
  parameter int unsigned N_W  = 11,
  parameter int unsigned A_W  = 7,
  parameter int unsigned PC_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            primed,
  input logic            wrap,
  input logic            load,
  input logic            cycle_end,
  input logic            cmp_pulse,
  input logic [PC_W-1:0] pre_cnt,
  input logic [PC_W-1:0] p_act,
  input logic [PC_W-1:0] p_nxt,
  input logic [N_W-1:0]  n_eff,
  input logic [A_W-1:0]  a_eff,
  input logic [N_W-1:0]  n_left,
  input logic [A_W-1:0]  a_left
);

  int unsigned span;
  int unsigned span_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span     <= 0;
      span_exp <= 0;
    end else if (load) begin
      span     <= 0;
      span_exp <= swdiv_pkg::full_ratio(32'(p_nxt), 32'(n_eff), 32'(a_eff));
    end else if (tick && primed) begin
      span <= span + 1;
    end
  end

  // R2
  ratio_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |-> (span + 1 == span_exp));

  // R1
  no_early_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !cmp_pulse);

  // R5
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (pre_cnt <= p_act));

  // R5
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !wrap && !load) |=> ($stable(n_left) && $stable(a_left)));

  // R8
  modulus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !load) |=> $stable(p_act));

  // R9
  pulse_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> cmp_pulse);

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse);

  // R10
  end_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |-> tick);

  // R2
  main_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (n_left != '0));

endmodule

bind swallow_fb_divider swdiv_chk #(.N_W(N_W), .A_W(A_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(vco_tick), .primed(primed), .wrap(wrap),
  .load(load), .cycle_end(cycle_end), .cmp_pulse(cmp_pulse),
  .pre_cnt(pre_cnt), .p_act(p_act), .p_nxt(p_nxt),
  .n_eff(n_eff), .a_eff(a_eff), .n_left(n_left), .a_left(a_left)
);

// File: tb/swallow_fb_divider_tb.sv
module swallow_fb_divider_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [10:0] n_in = 11'd5;
  logic [6:0]  a_in = 7'd2;
  logic        sel = 1'b1;
  logic        pulse_tx;
  logic        pulse_rx;

  int vectors = 0;
  int fails = 0;
  int tick_total = 0;
  int gap = 0;
  bit tick_en = 1'b0;
  bit armed = 1'b0;
  bit finished = 1'b0;
  string cur_tag = "R2";

  int    last_tc[2];
  int    exp_r[2];
  int    npulse[2];
  bit    prevp[2];
  string exp_tag[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_fb_divider #(.RX_CHAN(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .vco_tick(tick), .div_n(n_in), .div_a(a_in),
    .mod_sel(sel), .cmp_pulse(pulse_tx)
  );

  swallow_fb_divider #(.RX_CHAN(1'b1)) u_dut_rx (
    .clk(clk), .rst_n(rst_n), .vco_tick(tick), .div_n(n_in), .div_a(a_in),
    .mod_sel(sel), .cmp_pulse(pulse_rx)
  );

  // Ratio restated from the requirements: clamp N (R7), cap A at N (R6)
  function automatic int exp_ratio(input int ch, input int n, input int a, input bit s);
    int p;
    int ne;
    if (ch == 1) p = s ? 32 : 64;   // R4
    else         p = s ? 16 : 32;   // R3
    ne = (n < 3) ? 3 : n;
    if (a >= ne) return (p + 1) * ne;
    return p * ne + a;
  endfunction

  // Tick source with a gap every fifth clock (R10)
  always @(negedge clk) begin
    if (tick_en) begin
      gap = (gap + 1) % 5;
      tick = (gap != 0);
      if (tick) tick_total++;
    end else begin
      tick = 1'b0;
    end
  end

  task automatic check_chan(input int ch, input logic p);
    int meas;
    string chreq;
    chreq = (ch == 1) ? "R4" : "R3";
    if (prevp[ch]) begin
      vectors++;
      if (p) begin
        fails++;
        $display("FAIL R9 ch%0d pulse width: actual=2+ clocks expected=1 clock", ch);
      end
    end
    prevp[ch] = p;
    if (p) begin
      meas = tick_total - last_tc[ch];
      vectors++;
      // R2 / R5: segment arithmetic shows up in the tick count
      if (meas != exp_r[ch]) begin
        fails++;
        $display("FAIL %s %s ch%0d ticks per pulse: actual=%0d expected=%0d",
                 exp_tag[ch], chreq, ch, meas, exp_r[ch]);
      end
      exp_r[ch]   = exp_ratio(ch, int'(n_in), int'(a_in), sel);
      exp_tag[ch] = cur_tag;
      last_tc[ch] = tick_total;
      npulse[ch]++;
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (armed && !finished) begin
      check_chan(0, pulse_tx);
      check_chan(1, pulse_rx);
    end
  end

  task automatic apply_cfg(input int n, input int a, input bit s, input string tg);
    int s0;
    int s1;
    @(negedge clk);
    n_in = 11'(n);
    a_in = 7'(a);
    sel = s;
    cur_tag = tg;
    s0 = npulse[0];
    s1 = npulse[1];
    wait (npulse[0] >= s0 + 2 && npulse[1] >= s1 + 2);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      npulse[c] = 0;
      prevp[c] = 1'b0;
      last_tc[c] = 0;
      exp_r[c] = 0;
      exp_tag[c] = "R1";
    end
    // R1: output quiet in reset
    repeat (3) begin
      @(negedge clk);
      vectors++;
      if (pulse_tx || pulse_rx) begin
        fails++;
        $display("FAIL R1 pulse in reset: actual=%b%b expected=00", pulse_tx, pulse_rx);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R1: capture clock takes the current settings, no pulse
    vectors++;
    if (pulse_tx || pulse_rx) begin
      fails++;
      $display("FAIL R1 pulse at capture: actual=%b%b expected=00", pulse_tx, pulse_rx);
    end
    for (int c = 0; c < 2; c++) begin
      exp_r[c] = exp_ratio(c, int'(n_in), int'(a_in), sel);
      exp_tag[c] = "R1";
      last_tc[c] = tick_total;
    end
    armed = 1'b1;
    @(negedge clk);
    tick_en = 1'b1;

    // R2 sweep: every A below N for small N, both select values
    for (int s = 0; s < 2; s++) begin
      for (int n = 3; n <= 6; n++) begin
        for (int a = 0; a < n; a++) begin
          apply_cfg(n, a, s[0], "R2");
        end
      end
    end

    // R6: swallow count at or above N
    apply_cfg(4, 6, 1'b1, "R6");
    apply_cfg(3, 3, 1'b0, "R6");
    // R7: main count below the floor
    apply_cfg(1, 0, 1'b1, "R7");
    apply_cfg(0, 2, 1'b0, "R7");
    // R2: larger N with the largest A
    apply_cfg(200, 127, 1'b1, "R2");

    // R8: reprogram in the middle of a running cycle
    apply_cfg(4, 1, 1'b1, "R8");
    begin
      int w;
      int s0;
      int s1;
      w = npulse[0];
      wait (npulse[0] > w);
      repeat (25) @(negedge clk);
      n_in = 11'd6;
      a_in = 7'd3;
      sel = 1'b0;
      s0 = npulse[0];
      s1 = npulse[1];
      wait (npulse[0] >= s0 + 3 && npulse[1] >= s1 + 3);
    end

    @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL R2 watchdog: actual=no completion expected=completion");
      summary();
      $finish;
    end
  end

endmodule